// File: doc/BRIEF.md
# Auto-Zero Trigger and Release Controller

This block decides when the auto-zero (AZ) sequence of a low-frequency receiver front end should run while the receiver is in data receive mode. It counts transitions on the demodulated data line. When the count reaches a programmed target it issues a one-cycle AZ request, provided any selected level condition on the data line is also met. In the jitter mode the target moves by one edge, up or down, at random from one AZ to the next. It can also be made to wait until the data line sits at a chosen level.

A second, independent path produces the internal AZ control line from an external AZ-enable input. A rising AZ-enable passes straight through. Its falling edge can be stretched by zero, one or three ticks of a 250 kHz clock enable. One tick is half a period of a 125 kHz clock. Both two-bit configuration fields are held in registers inside the block that clear to zero on reset.

Top module: `az_trigger_ctrl`

## Requirements
- R1: After reset, azReq is 0, azCtrlOut equals azEnIn, and both configuration registers hold 00.
- R2: While rxModeEn is 0, azReq stays 0 and the edge counter is held at zero. Edges counted before a drop of rxModeEn do not count toward the next request.
- R3: dataIn passes through a two-flop synchronizer, and rising and falling transitions both count as edges. With a target of 1, azReq is high in the cycle after the third rising clock edge that follows the clock edge sampling the transition.
- R4: With trigMode 2'b00, azReq pulses each time the edge count since the previous request reaches the target.
- R5: With trigMode 2'b01, the target for each interval is the programmed count plus an offset of -1, 0 or +1, drawn anew after every request from a 16-bit maximal-length LFSR. The low bits map 00 to -1, 10 to +1 and 01 or 11 to 0. A result below 1 is clamped to 1.
- R6: With trigMode 2'b10, the request also needs the synchronized data level to be 0. The block keeps waiting for further edges until both conditions hold.
- R7: With trigMode 2'b11, the request also needs the synchronized data level to be 1.
- R8: azReq is a single-cycle pulse. The edge counter clears in the same cycle and starts again from the next edge.
- R9: An edgeCount value of 0 acts as a target of 1.
- R10: With relDelay 2'b00 or 2'b01, azCtrlOut falls together with azEnIn.
- R11: With relDelay 2'b10, azCtrlOut falls after one tickEn pulse following the fall of azEnIn. With 2'b11 it falls after three.
- R12: While azEnIn is 1, azCtrlOut is 1, so a rising azEnIn passes through without delay.
- R13: A new trigMode or relDelay value takes effect one clock after it is presented. A fall of azEnIn in that same clock uses the previous setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| rxModeEn | input | 1 | Data receive mode enable |
| dataIn | input | 1 | Demodulated data, asynchronous |
| tickEn | input | 1 | 250 kHz clock enable (half a 125 kHz period) |
| edgeCount | input | 4 | Programmed edge count per AZ |
| trigMode | input | 2 | Trigger mode select |
| relDelay | input | 2 | Release delay select |
| azEnIn | input | 1 | External AZ enable |
| azReq | output | 1 | One-cycle AZ start request |
| azCtrlOut | output | 1 | Internal AZ control line |

## Verification
A transition on dataIn reaches azReq three clock edges after the edge that samples it: two synchronizer flops and the counter come first, and the request register follows. The directed latency test samples at the falling clock edge after each of those three edges. The table-driven runs leave six cycles between data edges, so every request arrives before the next edge and is credited to the right interval. The release path is combinational for the undelayed cases and is sampled just after the input is driven. For the delayed codes the bench counts the tickEn pulses seen on rising edges after the load edge, until azCtrlOut drops.

// File: rtl/az_pkg.sv
package az_pkg;

  typedef enum logic [1:0] {
    TRIG_COUNT  = 2'b00,
    TRIG_JITTER = 2'b01,
    TRIG_LOW    = 2'b10,
    TRIG_HIGH   = 2'b11
  } trigModeT;

  // Strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic lfsrStep;
  } azStrobeT;

  localparam logic [1:0] OFS_MINUS = 2'b00;
  localparam logic [1:0] OFS_PLUS  = 2'b10;

endpackage

// File: rtl/az_trig_ctrl.sv
module az_trig_ctrl
  import az_pkg::*;
#(
  parameter int CNT_W = 4,
  localparam int CW = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxModeEn,
  input  logic [1:0]       trigModeIn,
  input  logic [1:0]       relDelayIn,
  input  logic [CNT_W-1:0] edgeCount,
  input  logic             edgeSeen,
  input  logic             syncData,
  input  logic [CW-1:0]    edgeCnt,
  input  logic [1:0]       lfsrLow,
  output azStrobeT         strobes,
  output logic [1:0]       relCode,
  output logic             azReq
);

  trigModeT trigReg;
  logic [CW-1:0] base;
  logic [CW-1:0] target;
  logic levelOk;
  logic fire;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trigReg <= TRIG_COUNT;
      relCode <= 2'b00;
    end else begin
      trigReg <= trigModeT'(trigModeIn);
      relCode <= relDelayIn;
    end
  end

  always_comb begin
    base = (edgeCount == '0) ? CW'(1) : {1'b0, edgeCount};
    target = base;
    if (trigReg == TRIG_JITTER) begin
      case (lfsrLow)
        OFS_MINUS: target = (base > CW'(1)) ? base - CW'(1) : CW'(1);
        OFS_PLUS:  target = base + CW'(1);
        default:   target = base;
      endcase
    end
  end

  always_comb begin
    case (trigReg)
      TRIG_LOW:  levelOk = !syncData;
      TRIG_HIGH: levelOk = syncData;
      default:   levelOk = 1'b1;
    endcase
  end

  assign fire = rxModeEn && (edgeCnt >= target) && levelOk;

  always_comb begin
    strobes.cntClr   = !rxModeEn || fire;
    strobes.cntInc   = rxModeEn && edgeSeen;
    strobes.lfsrStep = fire;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) azReq <= 1'b0;
    else       azReq <= fire;
  end

  // R8: request never lasts two cycles
  p_req_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    azReq |=> !azReq);

  // R2: a request only follows a cycle in receive mode
  p_req_rx_r2: assert property (@(posedge clk) disable iff (!rstN)
    azReq |-> $past(rxModeEn));

  // R6: a low-level-gated request only when the data was low
  p_level_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    (azReq && $past(trigReg) == TRIG_LOW) |-> !$past(syncData));

  // R7: a high-level-gated request only when the data was high
  p_level_high_r7: assert property (@(posedge clk) disable iff (!rstN)
    (azReq && $past(trigReg) == TRIG_HIGH) |-> $past(syncData));

endmodule

// File: rtl/az_datapath.sv
module az_datapath
  import az_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter logic [15:0] LFSR_SEED = 16'hACE1,
  localparam int CW = CNT_W + 1,
  localparam int HOLD_W = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          dataIn,
  input  logic          tickEn,
  input  logic          azEnIn,
  input  azStrobeT      strobes,
  input  logic [1:0]    relCode,
  output logic          edgeSeen,
  output logic          syncData,
  output logic [CW-1:0] edgeCnt,
  output logic [1:0]    lfsrLow,
  output logic          azCtrlOut
);

  localparam logic [15:0] LFSR_TAPS = 16'hB400;
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic syncMeta;
  logic prevData;
  logic [15:0] lfsr;
  logic prevAzEn;
  logic fallNow;
  logic [HOLD_W-1:0] holdCnt;

  // Synchronizer and edge detect
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncMeta <= 1'b0;
      syncData <= 1'b0;
      prevData <= 1'b0;
    end else begin
      syncMeta <= dataIn;
      syncData <= syncMeta;
      prevData <= syncData;
    end
  end

  assign edgeSeen = syncData ^ prevData;

  // Edge counter, clear wins over increment, saturates
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   edgeCnt <= '0;
    else if (strobes.cntClr)     edgeCnt <= '0;
    else if (strobes.cntInc && edgeCnt != CNT_MAX)
                                 edgeCnt <= edgeCnt + CW'(1);
  end

  // Galois LFSR for the jitter offset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lfsr <= LFSR_SEED;
    else if (strobes.lfsrStep)
      lfsr <= (lfsr >> 1) ^ (lfsr[0] ? LFSR_TAPS : 16'h0000);
  end

  assign lfsrLow = lfsr[1:0];

  // Release delay path
  assign fallNow = prevAzEn && !azEnIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevAzEn <= 1'b0;
      holdCnt  <= '0;
    end else begin
      prevAzEn <= azEnIn;
      if (azEnIn)
        holdCnt <= '0;
      else if (fallNow && relCode[1])
        holdCnt <= relCode[0] ? HOLD_W'(3) : HOLD_W'(1);
      else if (tickEn && holdCnt != '0)
        holdCnt <= holdCnt - HOLD_W'(1);
    end
  end

  assign azCtrlOut = azEnIn || (holdCnt != '0) || (fallNow && relCode[1]);

  // R2: a clear strobe leaves the counter at zero
  p_cnt_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.cntClr |=> edgeCnt == '0);

  // R12: the control line is high whenever the enable is high
  p_rise_pass_r12: assert property (@(posedge clk) disable iff (!rstN)
    azEnIn |-> azCtrlOut);

  // R10: undelayed codes release together with the enable
  p_nodelay_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!azEnIn && $past(azEnIn) && !relCode[1]) |-> !azCtrlOut);

  // R5: the LFSR never locks up in the all-zero state
  p_lfsr_live_r5: assert property (@(posedge clk) disable iff (!rstN)
    lfsr != 16'h0000);

endmodule

// File: rtl/az_trigger_ctrl.sv
module az_trigger_ctrl
  import az_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter logic [15:0] LFSR_SEED = 16'hACE1,
  localparam int CW = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxModeEn,
  input  logic             dataIn,
  input  logic             tickEn,
  input  logic [CNT_W-1:0] edgeCount,
  input  logic [1:0]       trigMode,
  input  logic [1:0]       relDelay,
  input  logic             azEnIn,
  output logic             azReq,
  output logic             azCtrlOut
);

  azStrobeT strobes;
  logic [1:0] relCode;
  logic edgeSeen;
  logic syncData;
  logic [CW-1:0] edgeCnt;
  logic [1:0] lfsrLow;

  az_trig_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .rxModeEn(rxModeEn),
    .trigModeIn(trigMode), .relDelayIn(relDelay), .edgeCount(edgeCount),
    .edgeSeen(edgeSeen), .syncData(syncData), .edgeCnt(edgeCnt),
    .lfsrLow(lfsrLow), .strobes(strobes), .relCode(relCode), .azReq(azReq)
  );

  az_datapath #(.CNT_W(CNT_W), .LFSR_SEED(LFSR_SEED)) dp_i (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .tickEn(tickEn),
    .azEnIn(azEnIn), .strobes(strobes), .relCode(relCode),
    .edgeSeen(edgeSeen), .syncData(syncData), .edgeCnt(edgeCnt),
    .lfsrLow(lfsrLow), .azCtrlOut(azCtrlOut)
  );

endmodule

// File: tb/az_trigger_ctrl_tb.sv
module az_trigger_ctrl_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxModeEn = 1'b0;
  logic dataIn = 1'b0;
  logic tickEn = 1'b0;
  logic [3:0] edgeCount = 4'd1;
  logic [1:0] trigMode = 2'b00;
  logic [1:0] relDelay = 2'b00;
  logic azEnIn = 1'b0;
  logic azReq;
  logic azCtrlOut;

  int checks = 0;
  int errors = 0;
  int pulseCnt = 0;
  int edgesSent = 0;
  int lastMark = 0;
  int randOn = 0;
  int curCount = 1;
  int gapSeen[6];
  int done = 0;

  az_trigger_ctrl dut_i (
    .clk(clk), .rstN(rstN), .rxModeEn(rxModeEn), .dataIn(dataIn),
    .tickEn(tickEn), .edgeCount(edgeCount), .trigMode(trigMode),
    .relDelay(relDelay), .azEnIn(azEnIn), .azReq(azReq), .azCtrlOut(azCtrlOut)
  );

  always #5 clk = ~clk;

  // 250 kHz tick stand-in: one pulse every four clocks
  initial begin
    int div = 0;
    forever begin
      @(negedge clk);
      div = div + 1;
      tickEn = (div % 4 == 0);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Pulse monitor; in jitter mode each interval is checked
  always @(negedge clk) begin
    if (azReq) begin
      pulseCnt++;
      if (randOn != 0) begin
        int gap;
        int lo;
        gap = edgesSent - lastMark;
        lo = (curCount > 1) ? curCount - 1 : 1;
        checks++;
        if (gap < lo || gap > curCount + 1) begin
          errors++;
          $display("FAIL R5: actual gap %0d expected %0d..%0d", gap, lo, curCount + 1);
        end
        if (gap >= 0 && gap < 6) gapSeen[gap]++;
      end
      lastMark = edgesSent;
    end
  end

  task automatic sendEdges(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      dataIn = ~dataIn;
      edgesSent++;
      repeat (6) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic restart(input logic lvl);
    @(negedge clk);
    rxModeEn = 1'b0;
    dataIn = lvl;
    repeat (5) @(negedge clk);
    rxModeEn = 1'b1;
    pulseCnt = 0;
    lastMark = edgesSent;
    @(negedge clk);
  endtask

  // Requirement-level model of the non-random modes
  function automatic int model(input int mode, input int cnt, input int lvl, input int n);
    int c = 0;
    int l = lvl;
    int p = 0;
    int tgt = (cnt == 0) ? 1 : cnt;
    bit ok;
    for (int i = 0; i < n; i++) begin
      c++;
      l = 1 - l;
      ok = (mode == 2) ? (l == 0) : (mode == 3) ? (l == 1) : 1'b1;
      if (c >= tgt && ok) begin
        p++;
        c = 0;
      end
    end
    return p;
  endfunction

  localparam int NV = 8;
  localparam int VMODE[NV] = '{0, 0, 0, 2, 2, 3, 3, 3};
  localparam int VCNT [NV] = '{3, 1, 0, 2, 3, 2, 1, 5};
  localparam int VLVL [NV] = '{0, 1, 0, 0, 1, 0, 1, 0};
  localparam int VEDG [NV] = '{10, 5, 5, 9, 12, 9, 7, 14};

  task automatic relTest(input logic [1:0] code, input int expTicks, input string req);
    int ticks;
    int steps;
    @(negedge clk);
    relDelay = code;
    repeat (2) @(negedge clk);
    azEnIn = 1'b1;
    #1;
    chk("R12", azCtrlOut, 1);
    repeat (3) @(negedge clk);
    azEnIn = 1'b0;
    #1;
    if (expTicks == 0) begin
      chk(req, azCtrlOut, 0);
    end else begin
      chk(req, azCtrlOut, 1);
      @(posedge clk);
      ticks = 0;
      steps = 0;
      while (azCtrlOut && steps < 100) begin
        @(posedge clk);
        if (tickEn) ticks++;
        @(negedge clk);
        #1;
        steps++;
      end
      chk(req, ticks, expTicks);
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 6; i++) gapSeen[i] = 0;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1", azReq, 0);
    chk("R1", azCtrlOut, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", azReq, 0);

    // R3/R8: latency of a single edge with target 1
    trigMode = 2'b00;
    edgeCount = 4'd1;
    restart(1'b0);
    dataIn = 1'b1;
    edgesSent++;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R3", azReq, 0);
    end
    @(negedge clk);
    chk("R3", azReq, 1);
    @(negedge clk);
    chk("R8", azReq, 0);
    repeat (4) @(negedge clk);

    // Table of vectors: R4, R6, R7, R8, R9
    for (int v = 0; v < NV; v++) begin
      trigMode = VMODE[v][1:0];
      edgeCount = VCNT[v][3:0];
      restart(VLVL[v][0]);
      sendEdges(VEDG[v]);
      chk((VMODE[v] == 2) ? "R6" : (VMODE[v] == 3) ? "R7" : (VCNT[v] == 0) ? "R9" : "R4",
          pulseCnt, model(VMODE[v], VCNT[v], VLVL[v], VEDG[v]));
    end

    // R2: no requests and no counting outside receive mode
    trigMode = 2'b00;
    edgeCount = 4'd3;
    restart(1'b0);
    rxModeEn = 1'b0;
    sendEdges(5);
    chk("R2", pulseCnt, 0);
    rxModeEn = 1'b1;
    sendEdges(2);
    @(negedge clk);
    rxModeEn = 1'b0;
    repeat (3) @(negedge clk);
    rxModeEn = 1'b1;
    sendEdges(2);
    chk("R2", pulseCnt, 0);
    sendEdges(1);
    chk("R2", pulseCnt, 1);

    // R5: jitter mode intervals
    trigMode = 2'b01;
    edgeCount = 4'd4;
    curCount = 4;
    restart(1'b0);
    randOn = 1;
    sendEdges(80);
    randOn = 0;
    begin
      int kinds = 0;
      for (int i = 0; i < 6; i++) if (gapSeen[i] > 0) kinds++;
      checks++;
      if (kinds < 2) begin
        errors++;
        $display("FAIL R5: actual %0d distinct gaps expected at least 2", kinds);
      end
    end
    edgeCount = 4'd1;
    curCount = 1;
    restart(1'b1);
    randOn = 1;
    sendEdges(20);
    randOn = 0;

    // Release path: R10, R11, R12
    rxModeEn = 1'b0;
    relTest(2'b00, 0, "R10");
    relTest(2'b01, 0, "R10");
    relTest(2'b10, 1, "R11");
    relTest(2'b11, 3, "R11");

    // R13: setting changes in the same clock as the fall use the old value
    relDelay = 2'b00;
    repeat (2) @(negedge clk);
    azEnIn = 1'b1;
    repeat (3) @(negedge clk);
    relDelay = 2'b11;
    azEnIn = 1'b0;
    #1;
    chk("R13", azCtrlOut, 0);
    repeat (20) @(negedge clk);
    chk("R13", azCtrlOut, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule